// File: doc/BRIEF.md
# Recirculating Character Entry Register

This block is the character stage of a serial refresh memory for a text display. The screen's characters circulate around a loop made of a fixed-latency delay memory and one character register. Every character clock (`adv_en`) moves the loop on by one slot. The register takes the next character from the delay output, presents it with its slot number and a cursor flag to the display path, and hands the previous character back to the delay memory. Any character that is not overwritten therefore returns to the register exactly one screen period later.

At the slot addressed by the cursor, a character from the keyboard or from the receive buffer can replace the recirculating one. The choice of source follows the operating mode on `mode`, where 0 is local, 1 is receive and 2 is transmit. In transmit mode, each bit strobe rotates the register left by one bit and drives the bit leaving the MSB onto a serial output. The transmit buffer therefore receives the character MSB first, and the character is whole again after one full byte of strobes.

Top module: `char_entry_loop`

## Requirements
- R1: While `rst` is high and after it falls, before the first advance, `disp_data`=0, `disp_cursor`=0, `wr_ack`=0, `ack_src`=0, `tx_bit`=0 and `disp_slot`=SLOTS-1.
- R2: Each cycle with `adv_en`=1 loads the next slot, so `disp_slot` steps by one and wraps from SLOTS-1 to 0.
- R3: A character that is not replaced reappears in the register unchanged exactly SLOTS advances after it was last loaded.
- R4: On each advance, `disp_cursor` becomes 1 exactly when the newly loaded slot number equals `cursor_addr`.
- R5: An advance with `kb_ld`=1 at the cursor slot loads `kb_data` in place of the recirculating character.
- R6: In receive mode (`mode`=1), an advance with `rx_ld`=1 at the cursor slot loads `rx_data`, and this takes priority over a keyboard strobe in the same cycle.
- R7: Outside receive mode, `rx_ld` is ignored. The slot then takes the keyboard character if `kb_ld` is set, and otherwise keeps the recirculated one.
- R8: Load strobes at a slot other than the cursor slot are ignored. The character recirculates and no acknowledge is raised.
- R9: `wr_ack` is high for exactly the cycle after a replacing write, with `ack_src`=1 for a receive-buffer write and 0 for a keyboard write. It is low after every other cycle.
- R10: In transmit mode (`mode`=2), a cycle with `bit_en`=1 and `adv_en`=0 copies the register MSB to `tx_bit` and rotates the register left by one. After 8 such cycles the character is restored and recirculates unchanged.
- R11: `bit_en` has no effect outside transmit mode or in a cycle with `adv_en`=1. In those cycles the register and `tx_bit` behave as without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Character clock: move the loop on by one slot |
| mode | input | 2 | 0 local, 1 receive, 2 transmit |
| cursor_addr | input | SLOT_W | Slot number of the cursor |
| kb_ld | input | 1 | Keyboard character offered |
| kb_data | input | W | Keyboard character |
| rx_ld | input | 1 | Receive-buffer character offered |
| rx_data | input | W | Receive-buffer character |
| bit_en | input | 1 | Serial readout bit strobe |
| disp_data | output | W | Character held in the register |
| disp_cursor | output | 1 | Cursor flag travelling with the character |
| disp_slot | output | SLOT_W | Slot number of the held character |
| wr_ack | output | 1 | Replacing-write acknowledge pulse |
| ack_src | output | 1 | Source of the acknowledged write: 1 receive buffer, 0 keyboard |
| tx_bit | output | 1 | Serial readout bit |

## Verification
A keyboard strobe and a receive-buffer strobe can arrive in the same advance at the cursor slot. The bench provokes this by raising both in receive mode while the cursor sits on a filled slot. The check passes only if the receive character lands, `ack_src` reads 1, and one frame later the same slot still holds that character and not the keyboard one. A bit strobe that coincides with an advance in transmit mode is also driven, and the loaded character and `tx_bit` must show no trace of a rotation.

// File: rtl/cer_pkg.sv
package cer_pkg;
  typedef enum logic [1:0] {
    MODE_LOCAL = 2'd0,
    MODE_RX    = 2'd1,
    MODE_TX    = 2'd2
  } cer_mode_e;

  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_KEY   = 2'd1,
    SRC_RXBUF = 2'd2
  } cer_src_e;
endpackage

// File: rtl/cer_slot_ctr.sv
module cer_slot_ctr #(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [SLOT_W-1:0] cursor_addr,
  output logic [SLOT_W-1:0] slot,
  output logic              at_cursor
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (adv) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot      = slot_q;
  assign at_cursor = (slot_q == cursor_addr);
endmodule

// File: rtl/cer_delay_line.sv
module cer_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 63
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      mem[ptr] <= din;
    end
  end

  assign dout = mem[ptr];
endmodule

// File: rtl/cer_src_sel.sv
module cer_src_sel
  import cer_pkg::*;
#(
  parameter int W = 8
) (
  input  cer_mode_e    mode,
  input  logic         at_cursor,
  input  logic         kb_ld,
  input  logic [W-1:0] kb_data,
  input  logic         rx_ld,
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] line_data,
  output logic [W-1:0] sel_data,
  output cer_src_e     sel_src
);
  always_comb begin
    sel_data = line_data;
    sel_src  = SRC_LINE;
    if (at_cursor) begin
      if (mode == MODE_RX && rx_ld) begin
        sel_data = rx_data;
        sel_src  = SRC_RXBUF;
      end else if (kb_ld) begin
        sel_data = kb_data;
        sel_src  = SRC_KEY;
      end
    end
  end
endmodule

// File: rtl/char_entry_loop.sv
module char_entry_loop
  import cer_pkg::*;
#(
  parameter int W      = 8,
  parameter int SLOTS  = 64,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] cursor_addr,
  input  logic              kb_ld,
  input  logic [W-1:0]      kb_data,
  input  logic              rx_ld,
  input  logic [W-1:0]      rx_data,
  input  logic              bit_en,
  output logic [W-1:0]      disp_data,
  output logic              disp_cursor,
  output logic [SLOT_W-1:0] disp_slot,
  output logic              wr_ack,
  output logic              ack_src,
  output logic              tx_bit
);
  localparam int DL_DEPTH = SLOTS - 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  cer_mode_e         mode_e;
  logic [SLOT_W-1:0] slot;
  logic              at_cursor;
  logic [W-1:0]      line_data;
  logic [W-1:0]      sel_data;
  cer_src_e          sel_src;
  logic              shift_go;

  assign mode_e   = cer_mode_e'(mode);
  assign shift_go = (mode_e == MODE_TX) && bit_en && !adv_en;

  cer_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .adv(adv_en), .cursor_addr(cursor_addr),
    .slot(slot), .at_cursor(at_cursor)
  );

  cer_delay_line #(.W(W), .DEPTH(DL_DEPTH)) u_line (
    .clk(clk), .rst(rst), .adv(adv_en), .din(disp_data), .dout(line_data)
  );

  cer_src_sel #(.W(W)) u_sel (
    .mode(mode_e), .at_cursor(at_cursor),
    .kb_ld(kb_ld), .kb_data(kb_data),
    .rx_ld(rx_ld), .rx_data(rx_data),
    .line_data(line_data),
    .sel_data(sel_data), .sel_src(sel_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_data   <= '0;
      disp_cursor <= 1'b0;
      disp_slot   <= LAST;
      wr_ack      <= 1'b0;
      ack_src     <= 1'b0;
      tx_bit      <= 1'b0;
    end else begin
      wr_ack  <= 1'b0;
      ack_src <= 1'b0;
      if (adv_en) begin
        disp_data   <= sel_data;
        disp_cursor <= at_cursor;
        disp_slot   <= slot;
        wr_ack      <= (sel_src != SRC_LINE);
        ack_src     <= (sel_src == SRC_RXBUF);
      end else if (shift_go) begin
        disp_data <= {disp_data[W-2:0], disp_data[W-1]};
        tx_bit    <= disp_data[W-1];
      end
    end
  end
endmodule

// File: rtl/cer_checker.sv
module cer_checker
  import cer_pkg::*;
#(
  parameter int W      = 8,
  parameter int SLOTS  = 64,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_en,
  input logic [1:0]        mode,
  input logic [SLOT_W-1:0] cursor_addr,
  input logic              kb_ld,
  input logic [W-1:0]      kb_data,
  input logic              rx_ld,
  input logic [W-1:0]      rx_data,
  input logic              bit_en,
  input logic [W-1:0]      disp_data,
  input logic              disp_cursor,
  input logic [SLOT_W-1:0] disp_slot,
  input logic              wr_ack,
  input logic              ack_src,
  input logic              tx_bit
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] nxt_slot;
  logic              rx_win;
  logic              rot_cyc;

  assign nxt_slot = (disp_slot == LAST) ? '0 : disp_slot + 1'b1;
  assign rx_win   = (mode == MODE_RX) && rx_ld;
  assign rot_cyc  = (mode == MODE_TX) && bit_en && !adv_en;

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> disp_slot == $past(nxt_slot)); // R2

  AST_CURSOR_FLAG: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> disp_cursor == ($past(cursor_addr) == $past(nxt_slot))); // R4

  AST_KEY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (adv_en && kb_ld && !rx_win && cursor_addr == nxt_slot)
      |=> (disp_data == $past(kb_data)) && wr_ack && !ack_src); // R5

  AST_RX_WRITE: assert property (@(posedge clk) disable iff (rst)
    (adv_en && rx_win && cursor_addr == nxt_slot)
      |=> (disp_data == $past(rx_data)) && wr_ack && ack_src); // R6

  AST_RX_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && ack_src) |-> $past(mode) == MODE_RX); // R7

  AST_ACK_AT_CURSOR: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> disp_cursor); // R8

  AST_ACK_AFTER_ADV: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> $past(adv_en)); // R9

  AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
    rot_cyc |=> (disp_data == {$past(disp_data[W-2:0]), $past(disp_data[W-1])})
               && (tx_bit == $past(disp_data[W-1]))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv_en && !rot_cyc) |=> $stable(disp_data) && $stable(disp_cursor)
                              && $stable(tx_bit)); // R11
endmodule

bind char_entry_loop cer_checker #(.W(W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cer_chk (
  .clk(clk), .rst(rst), .adv_en(adv_en), .mode(mode), .cursor_addr(cursor_addr),
  .kb_ld(kb_ld), .kb_data(kb_data), .rx_ld(rx_ld), .rx_data(rx_data),
  .bit_en(bit_en), .disp_data(disp_data), .disp_cursor(disp_cursor),
  .disp_slot(disp_slot), .wr_ack(wr_ack), .ack_src(ack_src), .tx_bit(tx_bit)
);

// File: tb/tb_char_entry_loop.sv
module tb_char_entry_loop;
  localparam int W      = 8;
  localparam int SLOTS  = 16;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [1:0] M_LOC = 2'd0, M_RX = 2'd1, M_TX = 2'd2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              adv_en = 1'b0;
  logic [1:0]        mode = M_LOC;
  logic [SLOT_W-1:0] cursor_addr = '0;
  logic              kb_ld = 1'b0;
  logic [W-1:0]      kb_data = '0;
  logic              rx_ld = 1'b0;
  logic [W-1:0]      rx_data = '0;
  logic              bit_en = 1'b0;
  logic [W-1:0]      disp_data;
  logic              disp_cursor;
  logic [SLOT_W-1:0] disp_slot;
  logic              wr_ack;
  logic              ack_src;
  logic              tx_bit;

  char_entry_loop #(.W(W), .SLOTS(SLOTS)) dut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .mode(mode), .cursor_addr(cursor_addr),
    .kb_ld(kb_ld), .kb_data(kb_data), .rx_ld(rx_ld), .rx_data(rx_data),
    .bit_en(bit_en), .disp_data(disp_data), .disp_cursor(disp_cursor),
    .disp_slot(disp_slot), .wr_ack(wr_ack), .ack_src(ack_src), .tx_bit(tx_bit)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0]      data;
    logic              chk_data;
    logic              cur;
    logic [SLOT_W-1:0] slot;
    logic              ack;
    logic              src;
    logic              tx;
    string             tag;
  } exp_t;

  exp_t         q[$];
  int           due = 0;
  int           n_chk = 0;
  int           n_bad = 0;

  logic [W-1:0] model [SLOTS];
  logic         known [SLOTS];
  int           mslot = 0;
  int           cslot = SLOTS - 1;
  logic         mcur = 1'b0;
  logic         mtx = 1'b0;

  task automatic check1(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic [1:0] m, input int cur,
                      input logic kl, input logic [W-1:0] kd,
                      input logic rl, input logic [W-1:0] rd, input string tag);
    exp_t e;
    @(negedge clk);
    adv_en = a; bit_en = b; mode = m; cursor_addr = SLOT_W'(cur);
    kb_ld = kl; kb_data = kd; rx_ld = rl; rx_data = rd;
    e.ack = 1'b0; e.src = 1'b0; e.tag = tag;
    if (a) begin
      logic at;
      at = (cur == mslot);
      if (at && m == M_RX && rl) begin
        model[mslot] = rd; known[mslot] = 1'b1; e.ack = 1'b1; e.src = 1'b1;
      end else if (at && kl) begin
        model[mslot] = kd; known[mslot] = 1'b1; e.ack = 1'b1;
      end
      mcur  = at;
      cslot = mslot;
      mslot = (mslot + 1) % SLOTS;
    end else if (b && m == M_TX) begin
      mtx = model[cslot][W-1];
      model[cslot] = {model[cslot][W-2:0], model[cslot][W-1]};
    end
    e.data = model[cslot]; e.chk_data = known[cslot];
    e.cur = mcur; e.slot = SLOT_W'(cslot); e.tx = mtx;
    q.push_back(e);
    @(posedge clk);
    due++;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (due > 0 && q.size() > 0) begin
        exp_t e;
        due--;
        e = q.pop_front();
        if (e.chk_data) check1(e.tag, "disp_data", 32'(disp_data), 32'(e.data));
        check1(e.tag, "disp_cursor", 32'(disp_cursor), 32'(e.cur));
        check1(e.tag, "disp_slot", 32'(disp_slot), 32'(e.slot));
        check1(e.tag, "wr_ack", 32'(wr_ack), 32'(e.ack));
        check1(e.tag, "ack_src", 32'(ack_src), 32'(e.src));
        check1(e.tag, "tx_bit", 32'(tx_bit), 32'(e.tx));
      end
    end
  end

  task automatic frame(input logic [1:0] m, input int cur, input int kslot_a, input int kslot_b,
                       input logic [W-1:0] kd, input int rslot, input logic [W-1:0] rd,
                       input string tag);
    for (int i = 0; i < SLOTS; i++) begin
      int s;
      s = mslot;
      step(1'b1, 1'b0, m, cur, (s == kslot_a) || (s == kslot_b), kd, (s == rslot), rd, tag);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < SLOTS; i++) begin model[i] = '0; known[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R1", "disp_data", 32'(disp_data), 0);
    check1("R1", "disp_cursor", 32'(disp_cursor), 0);
    check1("R1", "disp_slot", 32'(disp_slot), SLOTS - 1);
    check1("R1", "wr_ack", 32'(wr_ack), 0);
    check1("R1", "tx_bit", 32'(tx_bit), 0);
    rst = 1'b0;
    @(negedge clk);
    check1("R1", "disp_slot after release", 32'(disp_slot), SLOTS - 1);

    // R5 R2: fill every slot through the keyboard, cursor tracking the slot
    for (int i = 0; i < SLOTS; i++)
      step(1'b1, 1'b0, M_LOC, i, 1'b1, W'(8'h41 + i * 5), 1'b0, '0, "R5/R2 fill");
    // R3 R4: plain recirculation, cursor parked on slot 5
    frame(M_LOC, 5, -1, -1, '0, -1, '0, "R3/R4 recirc");
    // R8: strobe at slot 3 (off cursor) ignored, strobe at slot 9 (cursor) taken
    frame(M_LOC, 9, 3, 9, 8'hC3, 3, 8'h11, "R8/R5 off-cursor");
    // R6: receive and keyboard at the cursor slot together, receive wins
    frame(M_RX, 2, 2, -1, 8'h5A, 2, 8'hA5, "R6/R9 rx priority");
    frame(M_LOC, 2, -1, -1, '0, -1, '0, "R6/R3 rx kept");
    // R7: receive strobe outside receive mode
    frame(M_LOC, 7, -1, -1, '0, 7, 8'hEE, "R7 rx ignored");
    frame(M_TX, 11, 11, -1, 8'h96, 11, 8'h77, "R7/R9 kb in tx mode");
    // R10: serial readout of slot 0 after loading it
    step(1'b1, 1'b0, M_TX, 0, 1'b1, 8'hB2, 1'b0, '0, "R10 load");
    for (int i = 0; i < W; i++)
      step(1'b0, 1'b1, M_TX, 0, 1'b0, '0, 1'b0, '0, "R10 shift");
    // R11: strobe outside transmit mode, and strobe together with an advance
    step(1'b0, 1'b1, M_LOC, 0, 1'b0, '0, 1'b0, '0, "R11 local strobe");
    step(1'b0, 1'b1, M_RX, 0, 1'b0, '0, 1'b0, '0, "R11 rx strobe");
    step(1'b0, 1'b0, M_TX, 0, 1'b0, '0, 1'b0, '0, "R11 idle");
    step(1'b0, 1'b1, M_TX, 0, 1'b0, '0, 1'b0, '0, "R10 partial shift");
    for (int i = 1; i < W; i++)
      step(1'b0, 1'b1, M_TX, 0, 1'b0, '0, 1'b0, '0, "R10 finish shift");
    step(1'b1, 1'b1, M_TX, 0, 1'b0, '0, 1'b0, '0, "R11 strobe with advance");
    for (int i = 0; i < SLOTS; i++)
      step(1'b1, 1'b0, M_LOC, 4, 1'b0, '0, 1'b0, '0, "R10/R3 restored frame");

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule